// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block is the master side of a power-up configuration path. When reset ends, it selects an external serial flash by driving an active-low chip select. It then generates a serial clock that idles high. It sends a read opcode and a start address on an outgoing data line and gathers the returned bitstream from an incoming data line. The incoming bits are handed on as bytes, each with a one-cycle valid strobe, to whatever logic consumes the bitstream.

The block drives an open-drain done flag low from reset. Once the configured number of bits has arrived, it lets go of the flag, stops the serial clock and tri-states its flash-side outputs. It then waits for the done line to read high. An external agent may hold that line low for as long as it likes. After the line reads high, an initialization count runs. The count ticks on either an internal oscillator pulse or a user-supplied clock, chosen by a static select input. When the count expires, the block enters user mode and stays there until reset.

The controller is a state machine with these states, in order: ST_IDLE, ST_SELECT, ST_CMD, ST_ADDR, ST_READ, ST_RELEASE_DONE, ST_WAIT_DONE_HIGH, ST_INIT, ST_USER_MODE. The transitions are:
- ST_IDLE to ST_SELECT one cycle after reset.
- ST_SELECT to ST_CMD after one cycle, once the shift register is loaded.
- ST_CMD to ST_ADDR on the falling edge that sends the last opcode bit.
- ST_ADDR to ST_READ on the turnaround falling edge after the last address bit.
- ST_READ to ST_RELEASE_DONE on the falling edge that takes the final configuration bit.
- ST_RELEASE_DONE to ST_WAIT_DONE_HIGH unconditionally.
- ST_WAIT_DONE_HIGH to ST_INIT when the synchronized done line is high.
- ST_INIT to ST_USER_MODE when the tick count reaches its limit.

Top module: `cfgld_top`

## Requirements
- R1: While the synchronous reset is high, the outputs are cs_n=1, sclk=1, done_pull_low=1, pins_oe=1, user_mode=0 and cfg_byte_valid=0.
- R2: sclk idles high and makes a falling edge only while cs_n is low.
- R3: The first 32 bits presented on mosi are the opcode 0x03 followed by the 24-bit address 0x000000, most significant bit first. mosi changes only at falling sclk edges, so a receiver that captures on rising edges sees each bit.
- R4: miso is sampled at falling sclk edges. The first falling edge after the 32nd rising edge is a turnaround edge and is not sampled; every later falling edge in the read phase is sampled.
- R5: Each run of 8 samples forms one cfg_byte, with the first sample in bit 7. cfg_byte_valid is high for exactly one cycle per byte, and exactly CFG_BITS/8 bytes are produced.
- R6: In the cycle in which the last byte is strobed, done_pull_low drops to 0, cs_n returns high and sclk returns high. They stay there.
- R7: From the release onward, pins_oe is 0.
- R8: While done_in stays low after the release, user_mode stays 0 for any length of time.
- R9: The initialization phase counts INIT_CYCLES ticks of the selected source. With use_user_clk=0, a tick is one clk cycle with int_tick high. With use_user_clk=1, a tick is a rising edge of user_clk. Ticks from the source that is not selected, and ticks that arrive before done_in has been seen high, are not counted.
- R10: With use_user_clk=1 and no user_clk edges supplied, user_mode stays 0 indefinitely.
- R11: user_mode rises a few cycles after the INIT_CYCLES-th counted tick and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| use_user_clk | input | 1 | Initialization tick source: 0 internal tick, 1 user clock |
| int_tick | input | 1 | Internal oscillator tick, one-cycle pulse synchronous to clk |
| user_clk | input | 1 | User-supplied initialization clock, asynchronous |
| miso | input | 1 | Serial data returned by the flash |
| done_in | input | 1 | Level read back from the open-drain done line |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock to the flash, idle high |
| mosi | output | 1 | Command and address bits to the flash |
| pins_oe | output | 1 | Output enable for cs_n, sclk and mosi; 0 means tri-stated |
| done_pull_low | output | 1 | 1 pulls the done line low, 0 releases it |
| cfg_byte | output | 8 | Assembled configuration byte |
| cfg_byte_valid | output | 1 | One-cycle strobe for cfg_byte |
| user_mode | output | 1 | High once initialization has completed |

## Verification
The bench models a flash that captures on rising edges and launches each bit just after a falling edge. It checks the 32-bit command word and every streamed byte across several data seeds. A controller that sampled the turnaround edge would return every byte shifted by one bit. A controller that changed mosi on rising edges would corrupt the captured command. The bench records how many bytes had appeared when the done flag was released, so an early or late release shows up as a wrong count. It holds the done line low for a long stretch and offers ticks before initialization, from the source that is not selected, and one short of the limit. A counter that ran before the handshake, or that mixed the two sources, would reach user mode too soon. With the user clock selected and left idle, a design that had a hidden timeout would leave the waiting state on its own.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_CMD,
        ST_ADDR,
        ST_READ,
        ST_RELEASE_DONE,
        ST_WAIT_DONE_HIGH,
        ST_INIT,
        ST_USER_MODE
    } cfg_state_e;

    // Flash read opcode sent before the start address
    localparam logic [7:0] READ_OPCODE = 8'h03;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cfgld_sclk_gen.sv
module cfgld_sclk_gen #(
    parameter int HALF_DIV = 2,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_ev
);

    logic [CW-1:0] half_cnt;
    logic          sclk_q;
    logic          at_end;

    assign at_end = (half_cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_cnt <= '0;
            sclk_q   <= 1'b1;
        end else if (at_end) begin
            half_cnt <= '0;
            sclk_q   <= ~sclk_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // Edge marker: the coming clk edge takes sclk from high to low
    assign fall_ev = run && at_end && sclk_q;
    // Clock is forced back to its idle level as soon as the run ends
    assign sclk    = sclk_q | ~run;

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter
    import cfgld_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter logic [ADDR_BITS-1:0] START_ADDR = '0,
    parameter int CFG_BITS  = 1024,
    localparam int OPC_BITS = $bits(READ_OPCODE),
    localparam int TX_BITS  = OPC_BITS + ADDR_BITS,
    localparam int TXW      = $clog2(TX_BITS + 1),
    localparam int RXW      = $clog2(CFG_BITS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           shift_en,
    input  logic           sample_en,
    input  logic           miso,
    output logic           mosi,
    output logic [TXW-1:0] tx_cnt,
    output logic           rx_last,
    output logic [7:0]     byte_q,
    output logic           byte_valid
);

    logic [TX_BITS-1:0] tx_sr;
    logic [6:0]         rx_sr;
    logic [2:0]         rx_bit;
    logic [RXW-1:0]     rx_total;

    // Outgoing command and address, most significant bit first
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            tx_cnt <= '0;
            mosi   <= 1'b0;
        end else if (load) begin
            tx_sr  <= {READ_OPCODE, START_ADDR};
            tx_cnt <= '0;
        end else if (shift_en) begin
            mosi   <= tx_sr[TX_BITS-1];
            tx_sr  <= {tx_sr[TX_BITS-2:0], 1'b0};
            tx_cnt <= tx_cnt + 1'b1;
        end
    end

    // Incoming stream packed into bytes, first bit lands in bit 7
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr      <= '0;
            rx_bit     <= '0;
            rx_total   <= '0;
            byte_q     <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (load) begin
                rx_bit   <= '0;
                rx_total <= '0;
            end else if (sample_en) begin
                rx_sr    <= {rx_sr[5:0], miso};
                rx_bit   <= rx_bit + 1'b1;
                rx_total <= rx_total + 1'b1;
                if (rx_bit == 3'd7) begin
                    byte_q     <= {rx_sr, miso};
                    byte_valid <= 1'b1;
                end
            end
        end
    end

    assign rx_last = (rx_total == RXW'(CFG_BITS - 1));

endmodule

// File: rtl/cfgld_init_timer.sv
module cfgld_init_timer #(
    parameter int INIT_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ICW = $clog2(INIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    input  logic use_user_clk,
    input  logic int_tick,
    input  logic user_clk,
    output logic expired
);

    logic           uclk_s;
    logic           uclk_prev;
    logic           tick;
    logic [ICW-1:0] init_cnt;

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_uclk_sync (
        .clk (clk),
        .rst (rst),
        .d   (user_clk),
        .q   (uclk_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uclk_prev <= 1'b0;
        end else begin
            uclk_prev <= uclk_s;
        end
    end

    assign tick = use_user_clk ? (uclk_s & ~uclk_prev) : int_tick;

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            init_cnt <= '0;
        end else if (tick && !expired) begin
            init_cnt <= init_cnt + 1'b1;
        end
    end

    assign expired = (init_cnt == ICW'(INIT_CYCLES));

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int CFG_BITS    = 1024,
    parameter int INIT_CYCLES = 16,
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_BITS   = 24,
    parameter logic [ADDR_BITS-1:0] START_ADDR = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       use_user_clk,
    input  logic       int_tick,
    input  logic       user_clk,
    input  logic       miso,
    input  logic       done_in,
    output logic       cs_n,
    output logic       sclk,
    output logic       mosi,
    output logic       pins_oe,
    output logic       done_pull_low,
    output logic [7:0] cfg_byte,
    output logic       cfg_byte_valid,
    output logic       user_mode
);

    localparam int OPC_BITS = $bits(READ_OPCODE);
    localparam int TX_BITS  = OPC_BITS + ADDR_BITS;
    localparam int TXW      = $clog2(TX_BITS + 1);

    cfg_state_e     state_q;
    cfg_state_e     state_d;
    logic           run;
    logic           fall_ev;
    logic           load;
    logic           shift_en;
    logic           sample_en;
    logic           count_en;
    logic [TXW-1:0] tx_cnt;
    logic           rx_last;
    logic           done_s;
    logic           init_expired;

    cfgld_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .sclk    (sclk),
        .fall_ev (fall_ev)
    );

    cfgld_shifter #(
        .ADDR_BITS  (ADDR_BITS),
        .START_ADDR (START_ADDR),
        .CFG_BITS   (CFG_BITS)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .shift_en   (shift_en),
        .sample_en  (sample_en),
        .miso       (miso),
        .mosi       (mosi),
        .tx_cnt     (tx_cnt),
        .rx_last    (rx_last),
        .byte_q     (cfg_byte),
        .byte_valid (cfg_byte_valid)
    );

    cfgld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk (clk),
        .rst (rst),
        .d   (done_in),
        .q   (done_s)
    );

    cfgld_init_timer #(
        .INIT_CYCLES (INIT_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_init (
        .clk          (clk),
        .rst          (rst),
        .count_en     (count_en),
        .use_user_clk (use_user_clk),
        .int_tick     (int_tick),
        .user_clk     (user_clk),
        .expired      (init_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:           state_d = ST_SELECT;
            ST_SELECT:         state_d = ST_CMD;
            ST_CMD: begin
                if (fall_ev && tx_cnt == TXW'(OPC_BITS - 1)) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (fall_ev && tx_cnt == TXW'(TX_BITS)) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (fall_ev && rx_last) begin
                    state_d = ST_RELEASE_DONE;
                end
            end
            ST_RELEASE_DONE:   state_d = ST_WAIT_DONE_HIGH;
            ST_WAIT_DONE_HIGH: begin
                if (done_s) begin
                    state_d = ST_INIT;
                end
            end
            ST_INIT: begin
                if (init_expired) begin
                    state_d = ST_USER_MODE;
                end
            end
            ST_USER_MODE:      state_d = ST_USER_MODE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        cs_n          = 1'b1;
        run           = 1'b0;
        pins_oe       = 1'b1;
        done_pull_low = 1'b1;
        user_mode     = 1'b0;
        load          = 1'b0;
        shift_en      = 1'b0;
        sample_en     = 1'b0;
        count_en      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SELECT: begin
                cs_n = 1'b0;
                load = 1'b1;
            end
            ST_CMD: begin
                cs_n     = 1'b0;
                run      = 1'b1;
                shift_en = fall_ev;
            end
            ST_ADDR: begin
                cs_n     = 1'b0;
                run      = 1'b1;
                // The fall after the final address bit is the turnaround
                shift_en = fall_ev && (tx_cnt != TXW'(TX_BITS));
            end
            ST_READ: begin
                cs_n      = 1'b0;
                run       = 1'b1;
                sample_en = fall_ev;
            end
            ST_RELEASE_DONE, ST_WAIT_DONE_HIGH: begin
                pins_oe       = 1'b0;
                done_pull_low = 1'b0;
            end
            ST_INIT: begin
                pins_oe       = 1'b0;
                done_pull_low = 1'b0;
                count_en      = 1'b1;
            end
            ST_USER_MODE: begin
                pins_oe       = 1'b0;
                done_pull_low = 1'b0;
                user_mode     = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int CFG_BITS = 1024
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic pins_oe,
    input logic done_pull_low,
    input logic done_in,
    input logic cfg_byte_valid,
    input logic user_mode
);

    int   byte_seen;
    logic done_seen_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_seen      <= 0;
            done_seen_high <= 1'b0;
        end else begin
            if (cfg_byte_valid) begin
                byte_seen <= byte_seen + 1;
            end
            if (done_in) begin
                done_seen_high <= 1'b1;
            end
        end
    end

    // R2: the serial clock is low only while the flash is selected
    a_r2_clock_only_when_selected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R3: outgoing bits change only at falling edges
    a_r3_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (pins_oe && !$stable(mosi)) |-> $fell(sclk));

    // R5: byte strobes are single cycles
    a_r5_single_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        cfg_byte_valid |=> !cfg_byte_valid);

    // R6: release happens exactly when the last byte is strobed
    a_r6_release_after_all_bytes: assert property (@(posedge clk) disable iff (rst)
        $fell(done_pull_low) |-> (byte_seen + int'(cfg_byte_valid) == CFG_BITS / 8));

    // R7: flash-side outputs are tri-stated once the done line is released
    a_r7_tristate_after_release: assert property (@(posedge clk) disable iff (rst)
        !done_pull_low |-> !pins_oe);

    // R8: user mode never starts without the done line having read high
    a_r8_user_mode_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(user_mode) |-> done_seen_high);

    // R11: user mode holds until reset
    a_r11_user_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        user_mode |=> user_mode);

endmodule

bind cfgld_top cfgld_checker #(.CFG_BITS(CFG_BITS)) u_cfgld_checker (
    .clk            (clk),
    .rst            (rst),
    .cs_n           (cs_n),
    .sclk           (sclk),
    .mosi           (mosi),
    .pins_oe        (pins_oe),
    .done_pull_low  (done_pull_low),
    .done_in        (done_in),
    .cfg_byte_valid (cfg_byte_valid),
    .user_mode      (user_mode)
);

// File: tb/tb_cfgld_top.sv
`timescale 1ns/1ps
module tb_cfgld_top;

    localparam int CFG_BITS    = 48;
    localparam int NBYTES      = CFG_BITS / 8;
    localparam int INIT_CYCLES = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       use_user_clk = 1'b0;
    logic       int_tick = 1'b0;
    logic       user_clk = 1'b0;
    logic       miso;
    logic       done_in;
    logic       ext_pull = 1'b0;
    logic       cs_n, sclk, mosi, pins_oe, done_pull_low;
    logic [7:0] cfg_byte;
    logic       cfg_byte_valid, user_mode;

    int errors = 0;
    int checks = 0;

    // Flash model and capture state
    logic [7:0]  seed = 8'h01;
    logic [31:0] cmd_word;
    int          cmd_cnt;
    int          out_idx;
    int          bad_clk = 0;
    logic [7:0]  cap [0:63];
    int          nbytes;
    logic        rel_seen;
    int          rel_bytes;

    always #4 clk = ~clk;

    // Open-drain line: low while pulled by the design or by the outside
    assign done_in = !done_pull_low && ext_pull;

    cfgld_top #(
        .CFG_BITS    (CFG_BITS),
        .INIT_CYCLES (INIT_CYCLES),
        .HALF_DIV    (2)
    ) dut (
        .clk            (clk),
        .rst            (rst),
        .use_user_clk   (use_user_clk),
        .int_tick       (int_tick),
        .user_clk       (user_clk),
        .miso           (miso),
        .done_in        (done_in),
        .cs_n           (cs_n),
        .sclk           (sclk),
        .mosi           (mosi),
        .pins_oe        (pins_oe),
        .done_pull_low  (done_pull_low),
        .cfg_byte       (cfg_byte),
        .cfg_byte_valid (cfg_byte_valid),
        .user_mode      (user_mode)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] s, input int k);
        return 8'((int'(s) * (k + 1)) ^ (k << 3) ^ 8'hA5);
    endfunction

    function automatic logic stream_bit(input logic [7:0] s, input int idx);
        logic [7:0] b;
        b = exp_byte(s, idx / 8);
        return b[7 - (idx % 8)];
    endfunction

    // Flash: capture on rising edges, launch data just after falling edges
    always @(posedge sclk or negedge sclk or posedge rst) begin
        if (rst) begin
            cmd_word = '0;
            cmd_cnt  = 0;
            out_idx  = 0;
            miso     = 1'b0;
        end else if (!cs_n) begin
            if (sclk) begin
                if (cmd_cnt < 32) begin
                    cmd_word = {cmd_word[30:0], mosi};
                    cmd_cnt  = cmd_cnt + 1;
                end
            end else if (cmd_cnt == 32) begin
                #1;
                miso    = stream_bit(seed, out_idx);
                out_idx = out_idx + 1;
            end
        end
    end

    always @(negedge sclk) begin
        if (cs_n) bad_clk = bad_clk + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            nbytes    = 0;
            rel_seen  = 1'b0;
            rel_bytes = 0;
        end else begin
            if (cfg_byte_valid) begin
                if (nbytes < 64) cap[nbytes] = cfg_byte;
                nbytes = nbytes + 1;
            end
            if (!done_pull_low && !rel_seen) begin
                rel_seen  = 1'b1;
                rel_bytes = nbytes;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_src(input logic user_src);
        if (user_src) begin
            user_clk = 1'b1;
            cyc(4);
            user_clk = 1'b0;
            cyc(4);
        end else begin
            int_tick = 1'b1;
            cyc(1);
            int_tick = 1'b0;
            cyc(3);
        end
    endtask

    task automatic run_cfg(input logic [7:0] s, input logic mode);
        int n;
        seed         = s;
        use_user_clk = mode;
        ext_pull     = 1'b0;
        rst          = 1'b1;
        cyc(3);
        // R1: reset levels {cs_n,sclk,done_pull_low,pins_oe,user_mode,valid}
        check("R1 reset outputs",
              {26'd0, cs_n, sclk, done_pull_low, pins_oe, user_mode, cfg_byte_valid},
              32'b111100);
        rst = 1'b0;
        n = 0;
        while (!rel_seen && n < 3000) begin
            cyc(1);
            n = n + 1;
        end
        cyc(2);
        check("R3 command word", cmd_word, 32'h0300_0000);
        check("R3 command bit count", cmd_cnt, 32);
        check("R5 byte count", nbytes, NBYTES);
        for (int k = 0; k < NBYTES; k++) begin
            check($sformatf("R4 R5 byte %0d seed %0h", k, s), {24'd0, cap[k]}, {24'd0, exp_byte(s, k)});
        end
        check("R6 bytes seen at release", rel_bytes, NBYTES);
        check("R6 idle levels after release", {29'd0, cs_n, sclk, done_pull_low}, 32'b110);
        check("R7 outputs tri-stated", {31'd0, pins_oe}, 32'd0);
        check("R2 no sclk fall while deselected", bad_clk, 0);
        // R8 and R9: ticks while the done line is still held low are ignored
        for (int t = 0; t < INIT_CYCLES + 1; t++) tick_src(mode);
        cyc(100);
        check("R8 waits while done low", {31'd0, user_mode}, 32'd0);
        ext_pull = 1'b1;
        cyc(10);
        for (int t = 0; t < 3; t++) tick_src(!mode);
        for (int t = 0; t < INIT_CYCLES - 1; t++) tick_src(mode);
        cyc(8);
        check("R9 one tick short of the limit", {31'd0, user_mode}, 32'd0);
        if (mode) begin
            cyc(300);
            check("R10 idle user clock holds off user mode", {31'd0, user_mode}, 32'd0);
        end
        tick_src(mode);
        cyc(8);
        check("R11 user mode after final tick", {31'd0, user_mode}, 32'd1);
        cyc(20);
        check("R11 user mode held", {31'd0, user_mode}, 32'd1);
        check("R7 outputs stay tri-stated", {31'd0, pins_oe}, 32'd0);
    endtask

    initial begin
        logic [7:0] seeds [0:4];
        seeds[0] = 8'h01;
        seeds[1] = 8'h5A;
        seeds[2] = 8'hFF;
        seeds[3] = 8'h00;
        seeds[4] = 8'h37;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 5; i++) begin
                run_cfg(seeds[i], m[0]);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule